// File: doc/BRIEF.md
# Split-Format Bundle Instruction Extractor

This block pulls one instruction out of a fixed 256-bit fetch bundle in which every instruction has a fixed 16-bit head and an optional tail of whole 8-bit units. The heads are packed upward from the low end of the bundle, just after a small count field. The tails are packed downward from the high end of the bundle, in the same instruction order. Any space between the two regions is left unused. Because every head sits at a fixed position, the tail length of every instruction is decoded at once. The only part that depends on earlier instructions is a short running sum that places each tail.

A fetch supplies the bundle and a program counter made of a bundle address and an instruction index. One clock later the block returns the selected head, its tail (zero above its length), the tail length, and the next sequential program counter. The block also checks a fetch that is marked as a branch target: the target index must not lie past the last valid instruction of the bundle.

Top module: `hat_extract`

## Requirements
- R1: Bundle layout. Bits [3:0] hold the index of the last valid instruction. Head k occupies bits [4+16k +: 16]. The low two bits of each head give its tail length in 8-bit units (0 to 3).
- R2: For a legal fetch, `head_o` is the head at the requested index.
- R3: Tails are packed from bit 255 downward in instruction order. The first unit of tail k is the unit just below all units of tails 0..k-1. Output unit u of the tail appears at `tail_o[8u +: 8]`, and units at or above the tail length read as zero.
- R4: `tail_len_o` equals the tail-length field of the selected head.
- R5: When the index is below the last valid index, the next program counter is the same bundle address with the index plus one.
- R6: When the index equals the last valid index, the next program counter is the bundle address plus one with index 0.
- R7: A fetch whose index is past the last valid index never gives `out_valid_o`. If it is marked as a branch target, it raises `illegal_o` one cycle later. If it is not marked, `illegal_o` stays low.
- R8: A last-instruction field of 15 is treated as 14, the highest index whose head fits in the bundle.
- R9: Results appear one clock after a fetch. In a cycle with no fetch, `out_valid_o` and `illegal_o` go low next cycle and the data outputs hold their values.
- R10: While reset is asserted, every output is zero.
- R11: The bundle address wraps modulo 2^16 when it is incremented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Fetch request this cycle |
| is_target_i | input | 1 | Fetch is a branch target; index is checked |
| pc_baddr_i | input | 16 | Bundle address part of the program counter |
| pc_idx_i | input | 4 | Instruction index part of the program counter |
| bundle_i | input | 256 | Bundle contents |
| out_valid_o | output | 1 | Extracted instruction is valid |
| illegal_o | output | 1 | Branch target index lay past the last instruction |
| head_o | output | 16 | Selected head |
| tail_o | output | 24 | Selected tail, zero-filled |
| tail_len_o | output | 2 | Tail length in units |
| next_baddr_o | output | 16 | Next sequential bundle address |
| next_idx_o | output | 4 | Next sequential instruction index |

## Verification
On every cycle, the assertions check that a valid result and an illegal-target flag never appear together. They check that the flag only follows a marked fetch and that idle cycles drop both strobes. They also check that the reported tail length matches the head's own field, that the tail is zero above that length, and that the next program counter either steps the index or wraps to the next bundle. Only the bench's scenarios can show the rest. That includes whether the right head and the right tail bytes were chosen from a packed bundle, and whether tail placement stays correct when several earlier instructions have mixed tail lengths. It also includes clamping of the count field, holding of data on idle cycles, and wraparound of the bundle address.

// File: rtl/hat_pkg.sv
package hat_pkg;
  localparam int BUNDLE_W  = 256;
  localparam int IDX_W     = 4;
  localparam int HEAD_W    = 16;
  localparam int UNIT_W    = 8;
  localparam int TLEN_W    = 2;
  localparam int BADDR_W   = 16;
  localparam int NHEADS    = (BUNDLE_W - IDX_W) / HEAD_W;
  localparam int HREGION_W = IDX_W + NHEADS * HEAD_W;
  localparam int MAX_UNITS = (1 << TLEN_W) - 1;
  localparam int TAIL_W    = MAX_UNITS * UNIT_W;
  localparam int NSLOTS    = BUNDLE_W / UNIT_W;
  localparam int SLOT_W    = $clog2(NSLOTS);
  localparam int OFF_W     = $clog2(NHEADS * MAX_UNITS + 1);
  localparam int POS_W     = OFF_W + 1;

  typedef logic [HEAD_W-1:0] head_t;
  typedef logic [TLEN_W-1:0] tlen_t;
  typedef logic [OFF_W-1:0]  off_t;

  // Highest index whose head still fits in the bundle.
  function automatic logic [IDX_W-1:0] clamp_last(input logic [IDX_W-1:0] f);
    return (f > IDX_W'(NHEADS - 1)) ? IDX_W'(NHEADS - 1) : f;
  endfunction

  function automatic tlen_t tlen_of(input head_t h);
    return h[TLEN_W-1:0];
  endfunction

  function automatic off_t add_len(input off_t o, input tlen_t l);
    return o + off_t'(l);
  endfunction
endpackage

// File: rtl/hat_head_decode.sv
module hat_head_decode
  import hat_pkg::*;
(
  input  logic [HREGION_W-1:0]             region_i,
  output logic [NHEADS-1:0][HEAD_W-1:0]    heads_o,
  output logic [NHEADS-1:0][TLEN_W-1:0]    tlens_o,
  output logic [IDX_W-1:0]                 last_o
);
  assign last_o = clamp_last(region_i[IDX_W-1:0]);

  // Every head sits at a fixed slot, so all tail lengths decode in parallel.
  for (genvar k = 0; k < NHEADS; k++) begin : g_head
    assign heads_o[k] = region_i[IDX_W + k*HEAD_W +: HEAD_W];
    assign tlens_o[k] = tlen_of(heads_o[k]);
  end
endmodule

// File: rtl/hat_tail_offset.sv
module hat_tail_offset
  import hat_pkg::*;
(
  input  logic [NHEADS-2:0][TLEN_W-1:0] tlens_i,
  output logic [NHEADS-1:0][OFF_W-1:0]  offs_o
);
  // Units consumed by the tails of all earlier instructions.
  assign offs_o[0] = '0;
  for (genvar k = 1; k < NHEADS; k++) begin : g_sum
    assign offs_o[k] = add_len(offs_o[k-1], tlens_i[k-1]);
  end
endmodule

// File: rtl/hat_tail_gather.sv
module hat_tail_gather
  import hat_pkg::*;
(
  input  logic [BUNDLE_W-1:0] bundle_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic [TLEN_W-1:0]   len_i,
  output logic [TAIL_W-1:0]   tail_o
);
  // Slot p is the p-th unit counted from the top of the bundle.
  logic [NSLOTS-1:0][UNIT_W-1:0] slot;
  for (genvar p = 0; p < NSLOTS; p++) begin : g_slot
    assign slot[p] = bundle_i[BUNDLE_W - (p+1)*UNIT_W +: UNIT_W];
  end

  always_comb begin
    tail_o = '0;
    for (int u = 0; u < MAX_UNITS; u++) begin
      logic [POS_W-1:0] pos;
      pos = {1'b0, off_i} + POS_W'(u);
      if ((u < int'(len_i)) && (pos < POS_W'(NSLOTS)))
        tail_o[u*UNIT_W +: UNIT_W] = slot[pos[SLOT_W-1:0]];
    end
  end
endmodule

// File: rtl/hat_pc_step.sv
module hat_pc_step
  import hat_pkg::*;
(
  input  logic [BADDR_W-1:0] baddr_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [IDX_W-1:0]   last_i,
  output logic [BADDR_W-1:0] nbaddr_o,
  output logic [IDX_W-1:0]   nidx_o,
  output logic               beyond_o
);
  logic at_end;
  assign at_end   = (idx_i == last_i);
  assign beyond_o = (idx_i > last_i);
  assign nbaddr_o = at_end ? baddr_i + BADDR_W'(1) : baddr_i;
  assign nidx_o   = at_end ? '0 : idx_i + IDX_W'(1);
endmodule

// File: rtl/hat_extract.sv
module hat_extract
  import hat_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid_i,
  input  logic                is_target_i,
  input  logic [BADDR_W-1:0]  pc_baddr_i,
  input  logic [IDX_W-1:0]    pc_idx_i,
  input  logic [BUNDLE_W-1:0] bundle_i,
  output logic                out_valid_o,
  output logic                illegal_o,
  output logic [HEAD_W-1:0]   head_o,
  output logic [TAIL_W-1:0]   tail_o,
  output logic [TLEN_W-1:0]   tail_len_o,
  output logic [BADDR_W-1:0]  next_baddr_o,
  output logic [IDX_W-1:0]    next_idx_o
);
  logic [NHEADS-1:0][HEAD_W-1:0] heads;
  logic [NHEADS-1:0][TLEN_W-1:0] tlens;
  logic [NHEADS-1:0][OFF_W-1:0]  offs;
  logic [IDX_W-1:0]              last_w;
  logic [IDX_W-1:0]              sel_idx;
  logic                          beyond_w;
  logic                          take_w;
  logic                          flag_w;
  logic [BADDR_W-1:0]            nbaddr_w;
  logic [IDX_W-1:0]              nidx_w;
  logic [TAIL_W-1:0]             tail_w;

  hat_head_decode u_dec (
    .region_i (bundle_i[HREGION_W-1:0]),
    .heads_o  (heads),
    .tlens_o  (tlens),
    .last_o   (last_w)
  );

  hat_tail_offset u_off (
    .tlens_i (tlens[NHEADS-2:0]),
    .offs_o  (offs)
  );

  hat_pc_step u_pc (
    .baddr_i  (pc_baddr_i),
    .idx_i    (pc_idx_i),
    .last_i   (last_w),
    .nbaddr_o (nbaddr_w),
    .nidx_o   (nidx_w),
    .beyond_o (beyond_w)
  );

  // An index past the last valid one selects a safe slot; its result is discarded.
  assign sel_idx = beyond_w ? last_w : pc_idx_i;
  assign take_w  = req_valid_i && !beyond_w;
  assign flag_w  = req_valid_i && is_target_i && beyond_w;

  hat_tail_gather u_tail (
    .bundle_i (bundle_i),
    .off_i    (offs[sel_idx]),
    .len_i    (tlens[sel_idx]),
    .tail_o   (tail_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o  <= 1'b0;
      illegal_o    <= 1'b0;
      head_o       <= '0;
      tail_o       <= '0;
      tail_len_o   <= '0;
      next_baddr_o <= '0;
      next_idx_o   <= '0;
    end else begin
      out_valid_o <= take_w;
      illegal_o   <= flag_w;
      if (take_w) begin
        head_o       <= heads[sel_idx];
        tail_o       <= tail_w;
        tail_len_o   <= tlens[sel_idx];
        next_baddr_o <= nbaddr_w;
        next_idx_o   <= nidx_w;
      end
    end
  end

  // R7
  valid_illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !out_valid_o);

  // R7
  illegal_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $past(req_valid_i && is_target_i));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid_i) |-> (!out_valid_o && !illegal_o));

  // R4
  tail_len_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (tail_len_o == head_o[TLEN_W-1:0]));

  // R3
  tail_empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && tail_len_o == '0) |-> (tail_o == '0));

  // R3
  tail_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && tail_len_o < TLEN_W'(MAX_UNITS)) |->
      (tail_o[TAIL_W-1 -: UNIT_W] == '0));

  // R5 R6
  next_pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |->
      ((next_idx_o == IDX_W'($past(pc_idx_i) + 1'b1) && next_baddr_o == $past(pc_baddr_i)) ||
       (next_idx_o == '0 && next_baddr_o == BADDR_W'($past(pc_baddr_i) + 1'b1))));
endmodule

// File: tb/hat_extract_bench.sv
module hat_extract_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         is_target = 1'b0;
  logic [15:0]  pc_baddr = '0;
  logic [3:0]   pc_idx = '0;
  logic [255:0] bundle = '0;
  logic         out_valid, illegal;
  logic [15:0]  head;
  logic [23:0]  tail;
  logic [1:0]   tail_len;
  logic [15:0]  next_baddr;
  logic [3:0]   next_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hat_extract u_hat_extract (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .is_target_i(is_target),
    .pc_baddr_i(pc_baddr), .pc_idx_i(pc_idx), .bundle_i(bundle),
    .out_valid_o(out_valid), .illegal_o(illegal), .head_o(head), .tail_o(tail),
    .tail_len_o(tail_len), .next_baddr_o(next_baddr), .next_idx_o(next_idx)
  );

  typedef struct packed {
    logic [3:0]  lf;
    logic [31:0] seed;
    logic [3:0]  idx;
    logic        tgt;
    logic [15:0] baddr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4'd4,  32'h1234_02E4, 4'd0,  1'b0, 16'h0010},
    '{4'd4,  32'h1234_02E4, 4'd3,  1'b0, 16'h0010},
    '{4'd4,  32'h1234_02E4, 4'd4,  1'b0, 16'h0010},
    '{4'd6,  32'hFFFF_FFFF, 4'd6,  1'b0, 16'h0200},
    '{4'd6,  32'hFFFF_FFFF, 4'd4,  1'b0, 16'h0200},
    '{4'd0,  32'h0000_0003, 4'd0,  1'b1, 16'h0033},
    '{4'd3,  32'h9ABC_00B6, 4'd5,  1'b1, 16'h0044},
    '{4'd3,  32'h9ABC_00B6, 4'd3,  1'b1, 16'h0044},
    '{4'd15, 32'h5555_5555, 4'd14, 1'b1, 16'h0100},
    '{4'd15, 32'h5555_5555, 4'd15, 1'b1, 16'h0100},
    '{4'd2,  32'h0F0F_0039, 4'd2,  1'b0, 16'hFFFF},
    '{4'd9,  32'hA5A5_3C3C, 4'd7,  1'b0, 16'h0777}
  };

  logic [15:0] exp_head [15];
  logic [23:0] exp_tail [15];
  logic [1:0]  exp_len  [15];

  // Builds a bundle by laying tails down one byte at a time from the top.
  task automatic build(input logic [3:0] lf, input logic [31:0] seed);
    int el  = (lf > 4'd14) ? 14 : int'(lf);
    int ptr = 256;
    int lo  = 4 + (el + 1) * 16;
    bundle = '0;
    bundle[3:0] = lf;
    for (int k = 0; k < 15; k++) begin
      logic [1:0] l;
      logic [15:0] h;
      exp_head[k] = '0; exp_tail[k] = '0; exp_len[k] = '0;
      if (k <= el) begin
        l = seed[2*k +: 2];
        if (ptr - int'(l) * 8 < lo) l = 2'd0;
        h = {(14'(k * 14'h0123) ^ seed[31:18]), l};
        bundle[4 + 16*k +: 16] = h;
        for (int u = 0; u < int'(l); u++) begin
          logic [7:0] b;
          b = 8'(seed[7:0] + 8'(k * 16 + u + 1));
          bundle[ptr-8 +: 8] = b;
          exp_tail[k][8*u +: 8] = b;
          ptr = ptr - 8;
        end
        exp_head[k] = h; exp_len[k] = l;
      end
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [15:0] ba, input logic [3:0] ix, input logic tg);
    @(negedge clk);
    req_valid = 1'b1; is_target = tg; pc_baddr = ba; pc_idx = ix;
    @(negedge clk);
    req_valid = 1'b0; is_target = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int el = (v.lf > 4'd14) ? 14 : int'(v.lf);
    logic bey = int'(v.idx) > el;
    build(v.lf, v.seed);
    fetch(v.baddr, v.idx, v.tgt);
    check("R7 valid", 32'(out_valid), 32'(!bey));
    check("R7 illegal", 32'(illegal), 32'(v.tgt && bey));
    if (!bey) begin
      check("R1,R2 head", 32'(head), 32'(exp_head[v.idx]));
      check("R3 tail", 32'(tail), 32'(exp_tail[v.idx]));
      check("R4 tail_len", 32'(tail_len), 32'(exp_len[v.idx]));
      if (int'(v.idx) == el) begin
        check("R6 R11 next bundle", 32'(next_baddr), 32'(16'(v.baddr + 16'd1)));
        check("R6 next index", 32'(next_idx), 32'd0);
      end else begin
        check("R5 next bundle", 32'(next_baddr), 32'(v.baddr));
        check("R5 next index", 32'(next_idx), 32'(v.idx + 4'd1));
      end
    end
  endtask

  initial begin
    // R10: outputs during reset
    repeat (3) @(negedge clk);
    check("R10 valid", 32'(out_valid), 32'd0);
    check("R10 illegal", 32'(illegal), 32'd0);
    check("R10 data", 32'(head) ^ 32'(tail) ^ 32'(next_baddr) ^ 32'(next_idx) ^ 32'(tail_len), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R8: field 15 behaves as 14 -> index 14 wraps to next bundle
    build(4'd15, 32'h0000_0001);
    fetch(16'h0050, 4'd14, 1'b0);
    check("R8 clamp valid", 32'(out_valid), 32'd1);
    check("R8 clamp wrap", 32'(next_idx), 32'd0);

    // R7: unmarked fetch past last is dropped without the flag
    build(4'd2, 32'h0000_0015);
    fetch(16'h0060, 4'd1, 1'b0);
    fetch(16'h0060, 4'd5, 1'b0);
    check("R7 unmarked valid", 32'(out_valid), 32'd0);
    check("R7 unmarked illegal", 32'(illegal), 32'd0);
    check("R7 unmarked hold", 32'(head), 32'(exp_head[1]));

    // R9: idle cycle drops valid and holds data even with new inputs
    fetch(16'h0060, 4'd2, 1'b0);
    pc_idx = 4'd0; bundle = ~bundle;
    @(negedge clk);
    check("R9 idle valid", 32'(out_valid), 32'd0);
    check("R9 idle head hold", 32'(head), 32'(exp_head[2]));
    check("R9 idle tail hold", 32'(tail), 32'(exp_tail[2]));
    check("R9 idle pc hold", 32'(next_baddr), 32'h0061);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule